// File: doc/BRIEF.md
# Selectable Morphological Edge Gradient Unit

This block turns three pixel streams that arrive already aligned into one edge-strength stream. The streams are the maximum-filtered (dilated) sample, the minimum-filtered (eroded) sample and the original sample, delayed upstream so that it lines up with the two filtered ones. Three differences are formed side by side on every valid pixel: dilated minus eroded (full gradient), original minus eroded (inner half edge) and dilated minus original (outer half edge). A runtime select picks one of them. The pick is then multiplied by a programmable gain, so that the edge can be made fainter or stronger before it is overlaid on video further down the chain.

A difference that would go negative is clamped to zero. This can happen when the centre tap is left out of the neighbourhood shape. The scaled value saturates at full scale. Two configuration words are written through a small write port: the select and the gain. Each pixel keeps the settings that were in force on the cycle it entered. The pipeline is two stages deep and takes a pixel on every cycle.

Top module: `edge_grad_unit`

## Requirements
- R1: With select code 2'b00, the output is dilated minus eroded.
- R2: With select code 2'b01, the output is original minus eroded.
- R3: With select code 2'b10, the output is dilated minus original.
- R4: With select code 2'b11, every valid output pixel is 0.
- R5: A selected difference that would be negative is clamped to 0 before scaling.
- R6: The gain is an unsigned 8-bit value with 4 fraction bits, so 0x10 is unity. The output is (gradient × gain) >> 4, with the fraction truncated, and a gain of 0 gives 0.
- R7: A scaled result above 255 is output as 255.
- R8: edge_valid is high exactly two cycles after each cycle in which in_valid is high, and low otherwise. Back-to-back pixels and gaps are both supported.
- R9: A write with cfg_addr 0 loads the select from cfg_wdata[1:0] and ignores bits [7:2]. A write with cfg_addr 1 loads the gain from cfg_wdata[7:0]. A write affects only pixels presented on later cycles. A pixel presented on the same cycle as the write, or earlier, keeps the old setting.
- R10: While reset is held, edge_valid and edge_px are 0, the select is 2'b00 and the gain is 0x10.
- R11: While edge_valid is low, edge_px keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = gradient select, 1 = gain |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | The three input pixels are valid |
| dil_px | input | 8 | Dilated pixel |
| ero_px | input | 8 | Eroded pixel |
| org_px | input | 8 | Aligned original pixel |
| edge_valid | output | 1 | Output pixel is valid |
| edge_px | output | 8 | Scaled edge pixel |

## Verification
On every cycle, the properties check the two-cycle valid alignment, the hold of the output between valid pixels and the reset values. They also check the forced zero for the unused select code, the zero from a null gain, the clamp of a negative inner difference and the exact full gradient at unity gain. The truncation and saturation of the gain arithmetic for arbitrary values are shown only by the bench's reference model. The same holds for the rule that a configuration write spares pixels already in flight, and for the outer and inner gradients under mixed gains.

// File: rtl/egu_pkg.sv
package egu_pkg;
   typedef enum logic [1:0] {
      GRAD_FULL  = 2'b00,
      GRAD_INNER = 2'b01,
      GRAD_OUTER = 2'b10,
      GRAD_NONE  = 2'b11
   } grad_sel_e;

   localparam int unsigned N_GRAD       = 3;
   localparam logic        CFG_ADDR_SEL = 1'b0;
   localparam logic        CFG_ADDR_MAG = 1'b1;
endpackage

// File: rtl/egu_cfg_regs.sv
module egu_cfg_regs
   import egu_pkg::*;
#(
   parameter int unsigned MAG_W    = 8,
   parameter int unsigned MAG_FRAC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_addr,
   input  logic [MAG_W-1:0] cfg_wdata,
   output grad_sel_e        sel_o,
   output logic [MAG_W-1:0] mag_o
);
   localparam logic [MAG_W-1:0] MAG_UNITY = MAG_W'(1) << MAG_FRAC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o <= GRAD_FULL;
         mag_o <= MAG_UNITY;
      end else if (cfg_we) begin
         if (cfg_addr == CFG_ADDR_SEL) begin
            sel_o <= grad_sel_e'(cfg_wdata[1:0]);
         end else begin
            mag_o <= cfg_wdata;
         end
      end
   end
endmodule

// File: rtl/egu_diff_stage.sv
module egu_diff_stage
   import egu_pkg::*;
#(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned MAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] dil_px,
   input  logic [PIX_W-1:0] ero_px,
   input  logic [PIX_W-1:0] org_px,
   input  grad_sel_e        sel,
   input  logic [MAG_W-1:0] mag,
   output logic             s1_valid,
   output logic [PIX_W-1:0] s1_grad,
   output logic [MAG_W-1:0] s1_mag
);
   logic [PIX_W-1:0] minuend    [N_GRAD];
   logic [PIX_W-1:0] subtrahend [N_GRAD];
   logic [PIX_W-1:0] cand       [N_GRAD];
   logic [PIX_W-1:0] picked;

   assign minuend[0]    = dil_px;
   assign subtrahend[0] = ero_px;
   assign minuend[1]    = org_px;
   assign subtrahend[1] = ero_px;
   assign minuend[2]    = dil_px;
   assign subtrahend[2] = org_px;

   for (genvar g = 0; g < N_GRAD; g++) begin : g_sub
      logic [PIX_W:0] wide;
      assign wide    = {1'b0, minuend[g]} - {1'b0, subtrahend[g]};
      assign cand[g] = wide[PIX_W] ? '0 : wide[PIX_W-1:0];
   end

   always_comb begin
      unique case (sel)
         GRAD_FULL:  picked = cand[0];
         GRAD_INNER: picked = cand[1];
         GRAD_OUTER: picked = cand[2];
         default:    picked = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_grad  <= '0;
         s1_mag   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_grad <= picked;
            s1_mag  <= mag;
         end
      end
   end
endmodule

// File: rtl/egu_scale_stage.sv
module egu_scale_stage #(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned MAG_W    = 8,
   parameter int unsigned MAG_FRAC = 4,
   parameter bit          ROUND    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s1_valid,
   input  logic [PIX_W-1:0] s1_grad,
   input  logic [MAG_W-1:0] s1_mag,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_px
);
   localparam int unsigned PW = PIX_W + MAG_W;

   logic [PW-1:0]    prod;
   logic [PW-1:0]    biased;
   logic [PW-1:0]    shifted;
   logic [PIX_W-1:0] clipped;

   assign prod = PW'(s1_grad) * PW'(s1_mag);

   if (ROUND && (MAG_FRAC > 0)) begin : g_round
      assign biased = prod + (PW'(1) << (MAG_FRAC - 1));
   end else begin : g_trunc
      assign biased = prod;
   end

   assign shifted = biased >> MAG_FRAC;
   assign clipped = (|shifted[PW-1:PIX_W]) ? '1 : shifted[PIX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_px    <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            out_px <= clipped;
         end
      end
   end
endmodule

// File: rtl/edge_grad_unit.sv
module edge_grad_unit
   import egu_pkg::*;
#(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned MAG_W    = 8,
   parameter int unsigned MAG_FRAC = 4,
   parameter bit          ROUND    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_addr,
   input  logic [MAG_W-1:0] cfg_wdata,
   input  logic             in_valid,
   input  logic [PIX_W-1:0] dil_px,
   input  logic [PIX_W-1:0] ero_px,
   input  logic [PIX_W-1:0] org_px,
   output logic             edge_valid,
   output logic [PIX_W-1:0] edge_px
);
   if (MAG_FRAC >= MAG_W) begin : g_bad_frac
      $error("MAG_FRAC must be smaller than MAG_W");
   end
   if (MAG_W < 2) begin : g_bad_magw
      $error("MAG_W must hold the two select bits");
   end
   if (PIX_W < 2) begin : g_bad_pixw
      $error("PIX_W must be at least 2");
   end

   grad_sel_e        sel_q;
   logic [MAG_W-1:0] mag_q;
   logic             s1_valid;
   logic [PIX_W-1:0] s1_grad;
   logic [MAG_W-1:0] s1_mag;

   egu_cfg_regs #(.MAG_W(MAG_W), .MAG_FRAC(MAG_FRAC)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sel_o(sel_q), .mag_o(mag_q)
   );

   egu_diff_stage #(.PIX_W(PIX_W), .MAG_W(MAG_W)) u_diff (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .dil_px(dil_px), .ero_px(ero_px), .org_px(org_px),
      .sel(sel_q), .mag(mag_q),
      .s1_valid(s1_valid), .s1_grad(s1_grad), .s1_mag(s1_mag)
   );

   egu_scale_stage #(.PIX_W(PIX_W), .MAG_W(MAG_W), .MAG_FRAC(MAG_FRAC), .ROUND(ROUND)) u_scale (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_grad(s1_grad),
      .s1_mag(s1_mag), .out_valid(edge_valid), .out_px(edge_px)
   );
endmodule

// File: rtl/egu_checker.sv
module egu_checker #(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned MAG_W    = 8,
   parameter int unsigned MAG_FRAC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [PIX_W-1:0] dil_px,
   input logic [PIX_W-1:0] ero_px,
   input logic [PIX_W-1:0] org_px,
   input logic [1:0]       sel,
   input logic [MAG_W-1:0] mag,
   input logic             edge_valid,
   input logic [PIX_W-1:0] edge_px
);
   localparam logic [MAG_W-1:0] UNITY = MAG_W'(1) << MAG_FRAC;

   assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 edge_valid);
   assert_idle_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !edge_valid);
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_valid |-> $stable(edge_px));
   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |=> (!edge_valid && edge_px == '0 && sel == 2'b00 && mag == UNITY));
   assert_none_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == 2'b11) |-> ##2 (edge_px == '0));
   assert_zero_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mag == '0) |-> ##2 (edge_px == '0));
   assert_inner_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == 2'b01 && org_px < ero_px) |-> ##2 (edge_px == '0));
   assert_full_unity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel == 2'b00 && mag == UNITY && dil_px >= ero_px)
      |-> ##2 (edge_px == $past(dil_px - ero_px, 2)));
endmodule

bind edge_grad_unit egu_checker #(.PIX_W(PIX_W), .MAG_W(MAG_W), .MAG_FRAC(MAG_FRAC)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .dil_px(dil_px), .ero_px(ero_px), .org_px(org_px),
   .sel(sel_q), .mag(mag_q),
   .edge_valid(edge_valid), .edge_px(edge_px)
);

// File: tb/test_edge_grad_unit.sv
module test_edge_grad_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic       cfg_addr = 1'b0;
   logic [7:0] cfg_wdata = 8'd0;
   logic       in_valid = 1'b0;
   logic [7:0] dil_px = 8'd0;
   logic [7:0] ero_px = 8'd0;
   logic [7:0] org_px = 8'd0;
   logic       edge_valid;
   logic [7:0] edge_px;

   int    n_checks = 0;
   int    n_fails = 0;
   bit    running = 1'b0;
   bit    done = 1'b0;
   string scn = "R10 reset";

   // reference model state
   int    m_sel = 0;
   int    m_mag = 16;
   bit    s1v = 1'b0;
   int    s1px = 0;
   string s1tag = "R10";
   bit    ov = 1'b0;
   int    opx = 0;
   string otag = "R10";

   always #4 clk = ~clk;

   edge_grad_unit i_edge_grad_unit (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .dil_px(dil_px),
      .ero_px(ero_px), .org_px(org_px), .edge_valid(edge_valid), .edge_px(edge_px)
   );

   function automatic int ref_edge(input int d, input int e, input int o,
                                   input int sel, input int mag, output string tag);
      int g;
      int r;
      case (sel)
         0:       begin g = d - e; tag = "R1"; end
         1:       begin g = o - e; tag = "R2"; end
         2:       begin g = d - o; tag = "R3"; end
         default: begin g = 0;     tag = "R4"; end
      endcase
      if (g < 0) begin g = 0; tag = "R5"; end
      r = (g * mag) / 16;
      if (r > 255) begin
         r = 255; tag = "R7";
      end else if (mag != 16 && sel != 3 && tag != "R5") begin
         tag = "R6";
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         if (s1v) begin opx = s1px; otag = s1tag; end
         ov  = s1v;
         s1v = in_valid;
         if (in_valid) s1px = ref_edge(dil_px, ero_px, org_px, m_sel, m_mag, s1tag);
         if (cfg_we) begin  // R9: takes effect for later pixels only
            if (cfg_addr == 1'b0) m_sel = int'(cfg_wdata[1:0]);
            else                  m_mag = int'(cfg_wdata);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s (%s): actual %0d expected %0d", tag, scn, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         check(edge_valid === ov, "R8", int'(edge_valid), int'(ov));
         if (ov) check(edge_px === 8'(opx), otag, int'(edge_px), opx);
         else    check(edge_px === 8'(opx), "R11", int'(edge_px), opx);
      end
   end

   task automatic drive(input bit v, input int d, input int e, input int o,
                        input bit we, input bit a, input int wd);
      @(negedge clk);
      in_valid  = v;
      dil_px    = 8'(d);
      ero_px    = 8'(e);
      org_px    = 8'(o);
      cfg_we    = we;
      cfg_addr  = a;
      cfg_wdata = 8'(wd);
   endtask

   task automatic px(input int d, input int e, input int o);
      drive(1'b1, d, e, o, 1'b0, 1'b0, 0);
   endtask

   task automatic wr(input bit a, input int wd);
      drive(1'b0, 0, 0, 0, 1'b1, a, wd);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0, 1'b0, 1'b0, 0);
   endtask

   initial begin
      // R10: outputs during reset
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(edge_valid === 1'b0, "R10", int'(edge_valid), 0);
         check(edge_px === 8'd0, "R10", int'(edge_px), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;

      scn = "R1 full gradient defaults";
      px(200, 50, 100); px(255, 0, 7); px(10, 10, 10); idle(3);

      scn = "R2 R5 inner gradient";
      wr(1'b0, 1);
      px(120, 40, 90); idle(1); px(120, 40, 30); px(9, 0, 255); idle(3);

      scn = "R3 R5 outer gradient";
      wr(1'b0, 2);
      px(200, 50, 60); px(100, 50, 150); px(255, 0, 0); idle(3);

      scn = "R4 unused select";
      wr(1'b0, 3);
      px(255, 0, 100); px(80, 20, 40); idle(3);

      scn = "R6 gain scaling";
      wr(1'b0, 0); wr(1'b1, 8'h08);
      px(201, 0, 0); px(3, 0, 0);
      wr(1'b1, 8'h24); px(50, 0, 0); px(7, 2, 4);
      wr(1'b1, 8'h00); px(255, 0, 0); idle(3);

      scn = "R7 saturation";
      wr(1'b1, 8'hFF); px(255, 0, 0); px(20, 0, 0); px(1, 0, 0);
      wr(1'b1, 8'h20); px(128, 0, 0); px(127, 0, 0); idle(3);

      scn = "R9 write timing and ignored select bits";
      wr(1'b1, 8'h10);
      px(100, 20, 60);
      drive(1'b1, 100, 20, 60, 1'b1, 1'b1, 8'h20);  // this pixel keeps unity
      px(100, 20, 60);                                // this one sees 2.0
      drive(1'b1, 100, 20, 60, 1'b1, 1'b0, 8'hFE);  // keeps full, upper bits dropped
      px(100, 20, 60);                                // outer gradient
      idle(3);

      scn = "R8 R11 random stream with gaps";
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r == 0)      wr(1'b0, $urandom_range(0, 255));
         else if (r == 1) wr(1'b1, $urandom_range(0, 255));
         else if (r == 2) idle(1);
         else             px($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
      end
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule